// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a single-rank DDR2 SDRAM from power-up to normal operation. After reset it holds the clock enable low while it issues idle commands. It then raises the clock enable and steps through the mode-register programming sequence on the command pins, bank address and address bus. The steps are a precharge of all banks, the three extended mode registers, a DLL reset, two auto-refreshes, the final mode register, and an output-driver calibration default followed by an exit. Each minimum wait between two commands is a cycle count set by a parameter, so a system can size it for its clock and a bench can shorten it.

When the last extended-mode write has had its settling time, the block raises `init_done` and keeps it high until reset. From then on it produces a one-cycle `refresh_req` pulse at a fixed interval. A downstream controller arbitrates that request against normal traffic. The block has no data path and no handshake: every pin is a plain registered control output.

Top module: `ddr2i_seq`

## Requirements
- R1: While reset is active, `cke` is 0, the command is idle, and `init_done` and `refresh_req` are 0. After reset is released, `cke` stays 0 for `T_PWR` cycles and then rises with an idle command. It never falls again before the next reset.
- R2: The command field {cs_n,ras_n,cas_n,we_n} uses these codes: idle 0111, precharge-all 0010 with addr[10]=1, auto-refresh 0001, mode/extended-mode write 0000. Each non-idle command lasts exactly one cycle, and commands are issued only while `cke` is 1.
- R3: The first commands are a precharge-all, then a mode write with ba=10 and addr=0, then a mode write with ba=11 and addr=0, then a mode write with ba=01 and addr=0 (DLL enabled, addr[0]=0).
- R4: The next command is a mode write with ba=00 and the DLL-reset bit addr[8]=1.
- R5: Next come a precharge-all and then exactly two auto-refresh commands.
- R6: Next is a mode write with ba=00 and addr[8]=0. Its fields are burst-length code on addr[2:0] (`BL_CODE`), addr[3]=0, CAS latency 3 on addr[6:4]=011, and write-recovery code on addr[11:9] (`WR_CODE`). The reset-DLL write from R4 carries the same fields.
- R7: Next is a mode write with ba=01 and addr[9:7]=111 (calibration default), then a mode write with ba=01 and addr=0 (calibration exit).
- R8: Each gap, counted in cycles from one command to the next, is exact. It is `T_PRE` after the clock-enable rise and after each precharge-all. It is `T_MRD` after each mode write, except `T_DLL` after the DLL-enabling write. It is `T_RFC` after each auto-refresh.
- R9: `init_done` rises `T_MRD` cycles after the calibration-exit write and stays high until reset. No further non-idle command follows.
- R10: `refresh_req` is a one-cycle pulse. The first pulse comes `T_REFI` cycles after `init_done` rises, and later pulses follow every `T_REFI` cycles.
- R11: A reset applied in the middle of the sequence returns every output to its R1 state, and the full sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the mode register |
| addr | output | 14 | Address bus; carries mode-register fields |
| init_done | output | 1 | Sequence complete, held until reset |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The bench targets the exact gap before each command. A design that gives any step the wrong wait, such as `T_MRD` instead of `T_DLL` after the DLL enable or `T_PRE` instead of `T_RFC` after a refresh, shows up as a gap mismatch. It also checks the bank address and the mode bits, because swapping the ba codes for the second and third extended registers, or leaving the DLL-reset bit set in the final mode write, would program the device wrongly. Further targets are a dropped or doubled auto-refresh, a `refresh_req` that is two cycles wide or off by one in period, and a reset in mid-sequence that fails to restart from the idle phase with the clock enable low.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;
  localparam int ADDR_W    = 14;
  localparam int NUM_STEPS = 13;
  localparam int STEP_W    = 4;

  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PREA = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    W_PWR, W_PRE, W_MRD, W_DLL, W_RFC
  } wait_e;

  typedef struct packed {
    logic              cke;
    cmd_e              cmd;
    logic [1:0]        ba;
    logic [ADDR_W-1:0] addr;
    wait_e             wsel;
  } step_t;
endpackage

// File: rtl/ddr2i_step_rom.sv
module ddr2i_step_rom
  import ddr2i_pkg::*;
#(
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter logic [2:0] WR_CODE = 3'b001
) (
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  localparam logic [2:0] CL_CODE = 3'b011;

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w        = '0;
    w[2:0]   = BL_CODE;
    w[6:4]   = CL_CODE;
    w[8]     = dll_rst;
    w[11:9]  = WR_CODE;
    return w;
  endfunction

  localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] OCD_DFLT  = ADDR_W'(7) << 7;

  always_comb begin
    step = '{cke: 1'b1, cmd: CMD_NOP, ba: 2'b00, addr: '0, wsel: W_MRD};
    unique case (idx)
      4'd0:  step = '{1'b0, CMD_NOP,  2'b00, '0,               W_PWR};
      4'd1:  step = '{1'b1, CMD_NOP,  2'b00, '0,               W_PRE};
      4'd2:  step = '{1'b1, CMD_PREA, 2'b00, PREA_ADDR,        W_PRE};
      4'd3:  step = '{1'b1, CMD_MODE, 2'b10, '0,               W_MRD};
      4'd4:  step = '{1'b1, CMD_MODE, 2'b11, '0,               W_MRD};
      4'd5:  step = '{1'b1, CMD_MODE, 2'b01, '0,               W_DLL};
      4'd6:  step = '{1'b1, CMD_MODE, 2'b00, mode_word(1'b1),  W_MRD};
      4'd7:  step = '{1'b1, CMD_PREA, 2'b00, PREA_ADDR,        W_PRE};
      4'd8:  step = '{1'b1, CMD_REF,  2'b00, '0,               W_RFC};
      4'd9:  step = '{1'b1, CMD_REF,  2'b00, '0,               W_RFC};
      4'd10: step = '{1'b1, CMD_MODE, 2'b00, mode_word(1'b0),  W_MRD};
      4'd11: step = '{1'b1, CMD_MODE, 2'b01, OCD_DFLT,         W_MRD};
      4'd12: step = '{1'b1, CMD_MODE, 2'b01, '0,               W_MRD};
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2i_gap_timer.sv
module ddr2i_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr2i_refresh_timer.sv
module ddr2i_refresh_timer #(
  parameter int T_REFI = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int RW = $clog2(T_REFI + 1);
  localparam logic [RW-1:0] LAST = RW'(T_REFI - 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (run) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr2i_seq.sv
module ddr2i_seq
  import ddr2i_pkg::*;
#(
  parameter int         T_PWR   = 20000,
  parameter int         T_PRE   = 40,
  parameter int         T_MRD   = 2,
  parameter int         T_DLL   = 200,
  parameter int         T_RFC   = 14,
  parameter int         T_REFI  = 781,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter logic [2:0] WR_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int M1    = (T_PWR > T_PRE) ? T_PWR : T_PRE;
  localparam int M2    = (T_DLL > T_RFC) ? T_DLL : T_RFC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int WMAX  = (M3 > T_MRD) ? M3 : T_MRD;
  localparam int CNT_W = $clog2(WMAX + 1);
  localparam logic [STEP_W-1:0] END_STEP = STEP_W'(NUM_STEPS);

  logic [STEP_W-1:0] step_idx;
  step_t             cur;
  logic              expired, fire;
  logic [CNT_W-1:0]  wait_val;
  cmd_e              cmd_q;

  ddr2i_step_rom #(.BL_CODE(BL_CODE), .WR_CODE(WR_CODE)) u_rom (
    .idx (step_idx),
    .step(cur)
  );

  always_comb begin
    unique case (cur.wsel)
      W_PWR:   wait_val = CNT_W'(T_PWR - 1);
      W_PRE:   wait_val = CNT_W'(T_PRE - 1);
      W_DLL:   wait_val = CNT_W'(T_DLL - 1);
      W_RFC:   wait_val = CNT_W'(T_RFC - 1);
      default: wait_val = CNT_W'(T_MRD - 1);
    endcase
  end

  assign fire = expired && (step_idx != END_STEP);

  ddr2i_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fire),
    .load_val(wait_val),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_idx  <= '0;
      cke       <= 1'b0;
      cmd_q     <= CMD_NOP;
      ba        <= '0;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      if (fire) begin
        step_idx <= step_idx + 1'b1;
        cke      <= cur.cke;
        cmd_q    <= cur.cmd;
        ba       <= cur.ba;
        addr     <= cur.addr;
      end else begin
        cmd_q <= CMD_NOP;
        ba    <= '0;
        addr  <= '0;
      end
      if (step_idx == END_STEP && expired) init_done <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  ddr2i_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (init_done),
    .tick (refresh_req)
  );
endmodule

// File: rtl/ddr2i_seq_chk.sv
module ddr2i_seq_chk #(
  parameter int T_MRD = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [13:0] addr,
  input logic        init_done,
  input logic        refresh_req
);
  logic [3:0] code;
  logic       is_cmd;
  logic [7:0] gap_cnt;
  logic       seen_cmd;

  assign code   = {cs_n, ras_n, cas_n, we_n};
  assign is_cmd = (code != 4'b0111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      seen_cmd <= 1'b0;
    end else if (is_cmd) begin
      gap_cnt  <= 8'd1;
      seen_cmd <= 1'b1;
    end else if (gap_cnt != 8'hFF) begin
      gap_cnt  <= gap_cnt + 1'b1;
    end
  end

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> cke); // R2
  AST_CKE_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke); // R1
  AST_PREA_A10: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0010) |-> addr[10]); // R2
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && seen_cmd) |-> (gap_cnt >= 8'(T_MRD))); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !is_cmd); // R9
  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req); // R10
  AST_REF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done); // R10
endmodule

bind ddr2i_seq ddr2i_seq_chk #(.T_MRD(T_MRD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .init_done  (init_done),
  .refresh_req(refresh_req)
);

// File: tb/ddr2i_seq_test.sv
module ddr2i_seq_test;
  localparam int T_PWR  = 40;
  localparam int T_PRE  = 8;
  localparam int T_MRD  = 2;
  localparam int T_DLL  = 20;
  localparam int T_RFC  = 14;
  localparam int T_REFI = 50;
  localparam logic [2:0] BL = 3'b010;
  localparam logic [2:0] WR = 3'b001;

  localparam logic [3:0] K_MODE = 4'b0000, K_REF = 4'b0001, K_PREA = 4'b0010;
  localparam logic [3:0] K_CKE = 4'hA, K_DONE = 4'hD, K_RFSH = 4'hE;

  typedef struct {
    logic [3:0]  kind;
    logic [1:0]  ba;
    logic [13:0] addr;
    int          gap;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [1:0]  ba;
  logic [13:0] addr;

  int checks = 0;
  int failures = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  ddr2i_seq #(
    .T_PWR(T_PWR), .T_PRE(T_PRE), .T_MRD(T_MRD), .T_DLL(T_DLL),
    .T_RFC(T_RFC), .T_REFI(T_REFI), .BL_CODE(BL), .WR_CODE(WR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .refresh_req(refresh_req)
  );

  function automatic logic [13:0] mode_bits(input logic dll_rst);
    return {2'b00, WR, dll_rst, 1'b0, 3'b011, 1'b0, BL};
  endfunction

  task automatic push(input logic [3:0] k, input logic [1:0] b,
                      input logic [13:0] a, input int g, input string t);
    item_t it;
    it.kind = k; it.ba = b; it.addr = a; it.gap = g; it.tag = t;
    exp_q.push_back(it);
  endtask

  // Driver: expected events of one full bring-up, with gaps in cycles
  task automatic push_full_seq();
    push(K_CKE,  2'b00, 14'h0,    T_PWR, "R1");
    push(K_PREA, 2'b00, 14'h400,  T_PRE, "R3");
    push(K_MODE, 2'b10, 14'h0,    T_PRE, "R3");
    push(K_MODE, 2'b11, 14'h0,    T_MRD, "R3");
    push(K_MODE, 2'b01, 14'h0,    T_MRD, "R3");
    push(K_MODE, 2'b00, mode_bits(1'b1), T_DLL, "R4");
    push(K_PREA, 2'b00, 14'h400,  T_MRD, "R5");
    push(K_REF,  2'b00, 14'h0,    T_PRE, "R5");
    push(K_REF,  2'b00, 14'h0,    T_RFC, "R5");
    push(K_MODE, 2'b00, mode_bits(1'b0), T_RFC, "R6");
    push(K_MODE, 2'b01, 14'h380,  T_MRD, "R7");
    push(K_MODE, 2'b01, 14'h0,    T_MRD, "R7");
    push(K_DONE, 2'b00, 14'h0,    T_MRD, "R9");
    for (int i = 0; i < 3; i++) push(K_RFSH, 2'b00, 14'h0, T_REFI, "R10");
  endtask

  task automatic fail_msg(input string tag, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // Monitor: each observed event is popped and compared, gap included
  int cyc = 0, last_evt = 1;
  logic prev_cke = 1'b0, prev_done = 1'b0;

  task automatic observe(input logic [3:0] k, input logic [1:0] b, input logic [13:0] a);
    item_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fail_msg("R2", "unexpected event kind", int'(k), -1);
    end else begin
      e = exp_q.pop_front();
      if (k != e.kind)       fail_msg(e.tag, "kind", int'(k), int'(e.kind));
      else if (b != e.ba)    fail_msg(e.tag, "ba", int'(b), int'(e.ba));
      else if (a != e.addr)  fail_msg(e.tag, "addr", int'(a), int'(e.addr));
      else if (cyc - last_evt != e.gap)
        fail_msg((e.tag == "R10") ? "R10" : "R8", "gap", cyc - last_evt, e.gap);
    end
    last_evt = cyc;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_evt = 1; prev_cke = 1'b0; prev_done = 1'b0;
    end else begin
      cyc++;
      if (cke && !prev_cke) observe(K_CKE, 2'b00, 14'h0);
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) observe({cs_n, ras_n, cas_n, we_n}, ba, addr);
      if (init_done && !prev_done) observe(K_DONE, 2'b00, 14'h0);
      if (refresh_req) observe(K_RFSH, 2'b00, 14'h0);
      if (prev_cke && !cke) fail_msg("R1", "cke fell", 0, 1);
      if (prev_done && !init_done) fail_msg("R9", "init_done fell", 0, 1);
      prev_cke = cke; prev_done = init_done;
    end
  end

  task automatic check_reset_state(input string tag);
    checks++;
    if ({cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req} != 7'b0011100)
      fail_msg(tag, "reset outputs",
               int'({cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req}), 7'b0011100);
  endtask

  task automatic wait_drained(input int limit);
    int n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(negedge clk); n++;
    end
    checks++;
    if (exp_q.size() != 0) fail_msg("R5", "events missing", exp_q.size(), 0);
  endtask

  task automatic release_reset();
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    // Full bring-up plus three refresh periods (R3..R10)
    push_full_seq();
    release_reset();
    wait_drained(2000);
    repeat (T_REFI / 2) @(negedge clk);
    // Reset taken in the middle of the sequence (R11)
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("R11");
    push_full_seq();
    release_reset();
    repeat (60) @(negedge clk);
    #1 rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    check_reset_state("R11");
    push_full_seq();
    release_reset();
    wait_drained(2000);
    repeat (T_REFI / 2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule